// File: doc/BRIEF.md
# Framed serial word transmitter

The block takes words from a processor-side write port into a one-word holding register and sends them one bit at a time on a single data line. It sends them alongside a bit clock and a frame sync. The bit clock comes in as an input and is sampled in the system clock domain. All serial actions happen on its drive edge, which may be the rising or the falling edge. A frame begins in one of three ways: a frame sync pin from an external device, a frame pulse from a rate generator elsewhere in the chip, or an automatic pulse whenever a waiting word is copied into the shift register.

Once a frame begins, the word moves from the holding register into the shift register and the ready flag rises again. The first data bit follows one bit period after the frame sync. Word length is chosen from six values. 32-bit words may be sent least significant bit first. If a frame begins with the holding register empty, the previous word is sent again.

Top module: `framed_word_tx`

## Requirements
- R1: `cfg_len` selects the word length: code 0 gives 8 bits, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24, and codes 5, 6 and 7 give 32. Only the low bits of a written word, up to the selected length, are sent.
- R2: Without reversal, bits go out most significant first. With `cfg_lsb_first` = 1 and a 32-bit length, bit 0 goes first. With `cfg_lsb_first` = 1 and any other length, the order stays most significant first.
- R3: `cfg_drive_falling` = 0 updates `sdata_out` and `fs_out` after rising edges of `sclk_in`; a value of 1 updates them after falling edges.
- R4: `cfg_fs_active_low` = 0 makes the frame sync active high and 1 makes it active low. This applies to both `fs_out` and `fs_ext_in`. Otherwise `fs_out` rests at the inactive level.
- R5: With `cfg_fs_internal` = 0, a frame starts at a drive edge where `fs_ext_in` is at its active level. `fs_out` stays inactive in this mode.
- R6: With `cfg_fs_internal` = 1 and `cfg_fs_on_copy` = 0, a frame starts at a drive edge where `fs_gen_in` is high. `fs_out` is then active for that one bit period. A waiting word does not start a frame by itself.
- R7: With `cfg_fs_internal` = 1 and `cfg_fs_on_copy` = 1, a frame starts at the first drive edge with no word in progress and a word waiting. `fs_out` is active for that one bit period.
- R8: The first data bit is driven at the drive edge that follows the frame start edge. The remaining bits follow on consecutive drive edges.
- R9: `tx_ready` is high while the holding register is empty. It falls on the clock after a write and rises when a frame start copies the word into the shift register.
- R10: `sdata_out` is low whenever no data bit is due, including the frame start bit period.
- R11: A frame that starts with the holding register empty resends the last word sent. If no word has been sent since reset, that word is 0.
- R12: A frame sync that arrives while bits of a word remain to be sent is ignored.
- R13: After reset `tx_ready` is 1, `sdata_out` is 0 and `fs_out` is at the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 32 | Word to send |
| tx_ready | output | 1 | Holding register empty |
| sclk_in | input | 1 | Bit clock, slower than `clk` |
| fs_ext_in | input | 1 | External frame sync pin level |
| fs_gen_in | input | 1 | Rate generator frame pulse, active high |
| cfg_len | input | 3 | Word length code |
| cfg_lsb_first | input | 1 | Send 32-bit words bit 0 first |
| cfg_drive_falling | input | 1 | Drive data on falling bit clock edges |
| cfg_fs_active_low | input | 1 | Frame sync polarity |
| cfg_fs_internal | input | 1 | Frame sync made inside the block |
| cfg_fs_on_copy | input | 1 | Internal sync from word copy instead of rate generator |
| sdata_out | output | 1 | Serial data |
| fs_out | output | 1 | Frame sync output |

## Verification
`tx_ready` falls one system clock after a write, so the bench samples it on the next falling clock edge. Serial results trail each drive edge by the synchronizer depth plus one register, a few system clocks. The bench's reference deserializer therefore samples `sdata_out`, `fs_out` and its own frame sync pin on the opposite bit clock edge, half a bit period later, where every value is settled. The deserializer opens a word on the sample that sees the frame sync. It takes the next length's worth of samples as data, which checks the one-bit offset. It then compares each word in order against the queue the write task filled.

// File: rtl/txw_pkg.sv
// Shared constants, types and the word length decode for the framed word
// transmitter. Assumes a 32-bit maximum word.
package txw_pkg;
    localparam int WORD_W = 32;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // Length code decode: 0..4 step by four from eight, the rest are full width.
    function automatic cnt_t len_of(input logic [2:0] code);
        cnt_t n;
        if (code < 3'd5) n = cnt_t'(8 + 4 * int'(code));
        else             n = cnt_t'(WORD_W);
        return n;
    endfunction
endpackage

// File: rtl/txw_pin_sampler.sv
// Brings the bit clock and both frame sync pins into the system clock
// domain through an equal-depth synchronizer and flags one-cycle drive ticks.
// Assumes each bit clock phase lasts several system clocks.
module txw_pin_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic fs_ext_in,
    input  logic fs_gen_in,
    input  logic cfg_drive_falling,
    output logic tick,
    output logic fs_ext_s,
    output logic fs_gen_s
);
    localparam int NPIN = 3;

    logic [STAGES-1:0][NPIN-1:0] chain;
    logic sclk_prev;
    logic sclk_cur;

    // Synchronizer chain shared by all three pins so they stay aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= {fs_gen_in, fs_ext_in, sclk_in};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    // Remembers the previous synchronized bit clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_cur;
    end

    assign sclk_cur = chain[STAGES-1][0];
    assign fs_ext_s = chain[STAGES-1][1];
    assign fs_gen_s = chain[STAGES-1][2];

    // Drive tick on the selected edge of the synchronized bit clock.
    always_comb begin
        if (cfg_drive_falling) tick = sclk_prev & ~sclk_cur;
        else                   tick = ~sclk_prev & sclk_cur;
    end
endmodule

// File: rtl/txw_frame_ctl.sv
// Decides at each drive tick whether a frame starts, whether the holding
// register is consumed and whether the block pulses its own frame sync.
// Assumes idle means no bit of the current word remains.
module txw_frame_ctl (
    input  logic tick,
    input  logic idle,
    input  logic hold_full,
    input  logic fs_ext_s,
    input  logic fs_gen_s,
    input  logic cfg_fs_active_low,
    input  logic cfg_fs_internal,
    input  logic cfg_fs_on_copy,
    output logic start,
    output logic take_hold,
    output logic fs_pulse
);
    logic trigger;

    // Picks the frame trigger source from the mode bits.
    always_comb begin
        if (!cfg_fs_internal)   trigger = fs_ext_s ^ cfg_fs_active_low;
        else if (cfg_fs_on_copy) trigger = hold_full;
        else                     trigger = fs_gen_s;
    end

    assign start     = tick & idle & trigger;
    assign take_hold = start & hold_full;
    assign fs_pulse  = start & cfg_fs_internal;
endmodule

// File: rtl/txw_holding.sv
// One-word holding register between the write port and the shifter.
// A write in the same cycle as a take leaves the new word waiting.
module txw_holding
    import txw_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  word_t wr_data,
    input  logic  take,
    output word_t hold_data,
    output logic  hold_full
);
    // Loads on write, empties when the shifter takes the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_full <= 1'b0;
        end else begin
            if (take)  hold_full <= 1'b0;
            if (wr_en) begin
                hold_data <= wr_data;
                hold_full <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/txw_shifter.sv
// Shift register, bit counter and output registers. On a frame start it
// loads the waiting word (or the previous one on underrun), left-aligned
// for MSB-first order, and drives one bit per later tick.
module txw_shifter
    import txw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic       take_hold,
    input  word_t      hold_data,
    input  logic       fs_pulse,
    input  logic [2:0] cfg_len,
    input  logic       cfg_lsb_first,
    output logic       idle,
    output logic       dout,
    output logic       fs_act
);
    word_t shreg;
    word_t last_word;
    word_t word_sel;
    cnt_t  cnt;
    cnt_t  len;
    cnt_t  pad;
    logic  dir_lsb;
    logic  lsb_eff;

    // Word choice, length decode and alignment for the next frame.
    always_comb begin
        len      = len_of(cfg_len);
        pad      = cnt_t'(WORD_W) - len;
        lsb_eff  = cfg_lsb_first && (len == cnt_t'(WORD_W));
        word_sel = take_hold ? hold_data : last_word;
    end

    assign idle = (cnt == '0);

    // Frame load, per-tick shifting and idle-low output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            last_word <= '0;
            cnt       <= '0;
            dir_lsb   <= 1'b0;
            dout      <= 1'b0;
            fs_act    <= 1'b0;
        end else if (tick) begin
            if (start) begin
                last_word <= word_sel;
                shreg     <= lsb_eff ? word_sel : (word_sel << pad);
                dir_lsb   <= lsb_eff;
                cnt       <= len;
                dout      <= 1'b0;
                fs_act    <= fs_pulse;
            end else if (!idle) begin
                dout   <= dir_lsb ? shreg[0] : shreg[WORD_W-1];
                shreg  <= dir_lsb ? (shreg >> 1) : (shreg << 1);
                cnt    <= cnt - 1'b1;
                fs_act <= 1'b0;
            end else begin
                dout   <= 1'b0;
                fs_act <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/framed_word_tx.sv
// Top of the framed serial word transmitter: samples pins, holds one
// word, decides frame starts and shifts words out. Assumes configuration
// changes only while no word is in progress.
module framed_word_tx
    import txw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic        tx_ready,
    input  logic        sclk_in,
    input  logic        fs_ext_in,
    input  logic        fs_gen_in,
    input  logic [2:0]  cfg_len,
    input  logic        cfg_lsb_first,
    input  logic        cfg_drive_falling,
    input  logic        cfg_fs_active_low,
    input  logic        cfg_fs_internal,
    input  logic        cfg_fs_on_copy,
    output logic        sdata_out,
    output logic        fs_out
);
    logic  bit_tick;
    logic  fs_ext_s;
    logic  fs_gen_s;
    logic  idle;
    logic  hold_full;
    logic  start;
    logic  take_hold;
    logic  fs_pulse;
    logic  fs_act;
    word_t hold_data;

    txw_pin_sampler #(.STAGES(SYNC_STAGES)) u_pins (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .fs_ext_in(fs_ext_in),
        .fs_gen_in(fs_gen_in), .cfg_drive_falling(cfg_drive_falling),
        .tick(bit_tick), .fs_ext_s(fs_ext_s), .fs_gen_s(fs_gen_s)
    );

    txw_holding u_hold (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .take(take_hold), .hold_data(hold_data), .hold_full(hold_full)
    );

    txw_frame_ctl u_frame (
        .tick(bit_tick), .idle(idle), .hold_full(hold_full),
        .fs_ext_s(fs_ext_s), .fs_gen_s(fs_gen_s),
        .cfg_fs_active_low(cfg_fs_active_low),
        .cfg_fs_internal(cfg_fs_internal), .cfg_fs_on_copy(cfg_fs_on_copy),
        .start(start), .take_hold(take_hold), .fs_pulse(fs_pulse)
    );

    txw_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .tick(bit_tick), .start(start),
        .take_hold(take_hold), .hold_data(hold_data), .fs_pulse(fs_pulse),
        .cfg_len(cfg_len), .cfg_lsb_first(cfg_lsb_first),
        .idle(idle), .dout(sdata_out), .fs_act(fs_act)
    );

    assign tx_ready = ~hold_full;
    assign fs_out   = fs_act ^ cfg_fs_active_low;
endmodule

// File: rtl/txw_checker.sv
// Protocol checks for the framed word transmitter, bound to its top.
module txw_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic tx_ready,
    input logic sdata_out,
    input logic fs_out,
    input logic cfg_fs_active_low,
    input logic cfg_fs_internal,
    input logic cfg_fs_on_copy,
    input logic bit_tick
);
    // R3: data only moves right after a drive tick.
    assert_data_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata_out) |-> $past(bit_tick));

    // R4: frame sync level only moves after a tick unless polarity changed.
    assert_fs_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(fs_out) && $stable(cfg_fs_active_low)) |-> $past(bit_tick));

    // R9: a write leaves the holding register full.
    assert_wr_clears_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tx_ready);

    // R9: the register empties only at a drive tick.
    assert_ready_rise_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> $past(bit_tick));

    // R7: a copy in copy mode comes with an active frame sync.
    assert_copy_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_ready) && cfg_fs_internal && cfg_fs_on_copy && $stable(cfg_fs_active_low))
        |-> (fs_out != cfg_fs_active_low));

    // R5: in external mode a copy leaves the frame sync output inactive.
    assert_ext_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_fs_internal && $rose(tx_ready)) |-> (fs_out == cfg_fs_active_low));
endmodule

bind framed_word_tx txw_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tx_ready(tx_ready),
    .sdata_out(sdata_out), .fs_out(fs_out),
    .cfg_fs_active_low(cfg_fs_active_low), .cfg_fs_internal(cfg_fs_internal),
    .cfg_fs_on_copy(cfg_fs_on_copy), .bit_tick(bit_tick)
);

// File: tb/framed_word_tx_test.sv
// Scoreboard bench: the write task queues expected words and a reference
// deserializer on the non-drive bit clock edge pops and compares them.
module framed_word_tx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        tx_ready;
    logic        sclk_in = 1'b0;
    logic        fs_ext_in = 1'b0;
    logic        fs_gen_in = 1'b0;
    logic [2:0]  cfg_len = 3'd5;
    logic        cfg_lsb_first = 1'b0;
    logic        cfg_drive_falling = 1'b0;
    logic        cfg_fs_active_low = 1'b0;
    logic        cfg_fs_internal = 1'b1;
    logic        cfg_fs_on_copy = 1'b1;
    logic        sdata_out;
    logic        fs_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] exp_q[$];
    logic [31:0] last_sent = '0;
    int rx_left = 0;
    int rx_pos = 0;
    bit rx_lsb = 0;
    bit rx_busy = 0;
    logic [31:0] rx_acc = '0;
    logic [31:0] exp_w;
    bit fs_seen;

    framed_word_tx uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tx_ready(tx_ready), .sclk_in(sclk_in), .fs_ext_in(fs_ext_in),
        .fs_gen_in(fs_gen_in), .cfg_len(cfg_len), .cfg_lsb_first(cfg_lsb_first),
        .cfg_drive_falling(cfg_drive_falling), .cfg_fs_active_low(cfg_fs_active_low),
        .cfg_fs_internal(cfg_fs_internal), .cfg_fs_on_copy(cfg_fs_on_copy),
        .sdata_out(sdata_out), .fs_out(fs_out)
    );

    always #10 clk = ~clk;
    initial begin
        #5;
        forever #200 sclk_in = ~sclk_in;
    end

    function automatic int exp_len(input logic [2:0] code);
        case (code)
            3'd0: return 8;
            3'd1: return 12;
            3'd2: return 16;
            3'd3: return 20;
            3'd4: return 24;
            default: return 32;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_nondrive();
        if (cfg_drive_falling) @(posedge sclk_in);
        else                   @(negedge sclk_in);
    endtask

    task automatic wait_bits(input int n);
        for (int i = 0; i < n; i++) @(posedge sclk_in);
    endtask

    task automatic set_cfg(input logic [2:0] len, input bit lsb, input bit fall,
                           input bit low, input bit intl, input bit copy);
        cfg_len = len; cfg_lsb_first = lsb; cfg_drive_falling = fall;
        cfg_fs_active_low = low; cfg_fs_internal = intl; cfg_fs_on_copy = copy;
        fs_ext_in = low; fs_gen_in = 1'b0;
        wait_bits(2);
    endtask

    // Driver: writes a word and queues its expected serial image.
    task automatic send(input logic [31:0] w);
        logic [31:0] mask;
        while (!tx_ready) @(negedge clk);
        mask = (exp_len(cfg_len) == 32) ? 32'hFFFF_FFFF : ((32'd1 << exp_len(cfg_len)) - 1);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w;
        exp_q.push_back(w & mask);
        last_sent = w & mask;
        @(negedge clk);
        wr_en = 1'b0;
        chk(tx_ready == 1'b0, "R9 ready low after write", {31'd0, tx_ready}, 32'd0);
    endtask

    task automatic pulse_gen();
        wait_nondrive(); #2 fs_gen_in = 1'b1;
        wait_nondrive(); #2 fs_gen_in = 1'b0;
    endtask

    task automatic pulse_ext();
        wait_nondrive(); #2 fs_ext_in = ~cfg_fs_active_low;
        wait_nondrive(); #2 fs_ext_in = cfg_fs_active_low;
    endtask

    task automatic wait_done();
        int guard = 0;
        while ((exp_q.size() != 0 || rx_busy) && guard < 4000) begin
            @(posedge clk); guard++;
        end
        wait_bits(2);
    endtask

    // Reference deserializer and scoreboard monitor (R8 offset built in).
    always begin
        wait_nondrive();
        if (rst_n) begin
            if (rx_left > 0) begin
                if (rx_lsb) rx_acc[rx_pos] = sdata_out;
                else        rx_acc = {rx_acc[30:0], sdata_out};
                rx_pos++;
                rx_left--;
                if (rx_left == 0) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R12 unexpected word", rx_acc, 32'd0);
                    end else begin
                        exp_w = exp_q.pop_front();
                        chk(rx_acc == exp_w, "R1/R2/R8 received word", rx_acc, exp_w);
                    end
                    rx_busy = 0;
                end
            end else begin
                fs_seen = cfg_fs_internal ? (fs_out != cfg_fs_active_low)
                                          : (fs_ext_in != cfg_fs_active_low);
                chk(sdata_out == 1'b0, "R10 data low outside word", {31'd0, sdata_out}, 32'd0);
                if (fs_seen) begin
                    rx_left = exp_len(cfg_len);
                    rx_lsb  = cfg_lsb_first && (rx_left == 32);
                    rx_acc  = '0;
                    rx_pos  = 0;
                    rx_busy = 1;
                end
            end
            if (!cfg_fs_internal)
                chk(fs_out == cfg_fs_active_low, "R5 fs_out inactive in external mode",
                    {31'd0, fs_out}, {31'd0, cfg_fs_active_low});
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(tx_ready == 1'b1, "R13 reset ready", {31'd0, tx_ready}, 32'd1);
        chk(sdata_out == 1'b0, "R13 reset data", {31'd0, sdata_out}, 32'd0);
        chk(fs_out == 1'b0, "R13 reset fs", {31'd0, fs_out}, 32'd0);
        rst_n = 1'b1;

        // R11: underrun before any write sends zero (rate generator mode).
        set_cfg(3'd5, 0, 0, 0, 1, 0);
        exp_q.push_back(32'd0);
        pulse_gen();
        wait_done();

        // R7 and R1: copy mode, full length, MSB first.
        set_cfg(3'd5, 0, 0, 0, 1, 1);
        send(32'hA5C3_0F81);
        wait_done();
        chk(tx_ready == 1'b1, "R9 ready after copy", {31'd0, tx_ready}, 32'd1);

        // R9: second write while the first word shifts stays pending.
        send(32'h1234_5678);
        while (!tx_ready) @(negedge clk);
        send(32'h8765_4321);
        wait_bits(10);
        chk(tx_ready == 1'b0, "R9 ready low while word waits", {31'd0, tx_ready}, 32'd0);
        wait_done();

        // R1: every length code, including the two spare codes.
        for (int c = 0; c < 8; c++) begin
            set_cfg(3'(c), 0, 0, 0, 1, 1);
            send(32'hF0E1_D2C3 ^ (32'h0101_0101 * c));
            wait_done();
        end

        // R2: reversal at 32 bits, then ignored at 16 bits.
        set_cfg(3'd5, 1, 0, 0, 1, 1);
        send(32'h8000_0003);
        send(32'h0F0F_A5A1);
        wait_done();
        set_cfg(3'd2, 1, 0, 0, 1, 1);
        send(32'h0000_8001);
        wait_done();

        // R3 and R4: falling-edge drive with active-low frame sync.
        set_cfg(3'd4, 0, 1, 1, 1, 1);
        chk(fs_out == 1'b1, "R4 idle level active low", {31'd0, fs_out}, 32'd1);
        send(32'h00C0_FFEE);
        send(32'h0055_AA33);
        wait_done();

        // R6: a waiting word does not start a frame until the pulse.
        set_cfg(3'd5, 0, 0, 0, 1, 0);
        send(32'hDEAD_BEEF);
        wait_bits(4);
        chk(rx_busy == 1'b0, "R6 no frame without pulse", {31'd0, rx_busy}, 32'd0);
        chk(tx_ready == 1'b0, "R6 word still waiting", {31'd0, tx_ready}, 32'd0);
        pulse_gen();
        wait_done();

        // R11: underrun repeats the last word.
        exp_q.push_back(last_sent);
        pulse_gen();
        wait_done();

        // R12: a pulse in mid-word is ignored.
        send(32'h1357_9BDF);
        pulse_gen();
        wait_bits(8);
        pulse_gen();
        wait_done();
        wait_bits(40);
        chk(rx_busy == 1'b0 && exp_q.size() == 0, "R12 no extra frame",
            {31'd0, rx_busy}, 32'd0);

        // R5: external frame sync, active high and active low.
        set_cfg(3'd3, 0, 0, 0, 0, 0);
        send(32'h000A_BCDE);
        pulse_ext();
        wait_done();
        set_cfg(3'd5, 0, 1, 1, 0, 0);
        send(32'h7E81_4C2D);
        pulse_ext();
        wait_done();

        chk(exp_q.size() == 0, "R1 all words received", exp_q.size(), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule